// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one byte at a time over a three-wire synchronous link: a clock pin, a dedicated serial data output and a shared data pin that can either receive or mirror the output. The host loads a byte in parallel, pulses a start strobe, waits for the done flag and reads the received byte back in parallel. Each transfer shifts eight bits out and eight bits in at the same time.

The shift clock comes from one of two sources, and the choice can be changed at run time. In internal mode, a gated toggle driven by a shared power-of-two prescaler tap generates the clock and drives it onto the clock pin. In external mode, the clock pin is an input, and a two-flop synchronizer with an edge detector turns it into shift events. A static configuration input sets the bit order. When the serial function is disabled, the clock pin carries the prescaler tap as a free-running divided clock instead.

Top module: `sio_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy and done are 0 and rx_byte is 0.
- R2: When enable is 0, sck_oe is 1 and sck_o is a square wave that stays high for 2^(k-1) clock cycles per period. Here k is div_sel clamped to the range 1..12, so 0 counts as 1 and any value above 12 counts as 12.
- R3: In internal mode (enable 1, ext_clk 0), sck_oe is 1 and sck_o idles high. During a transfer each half period lasts exactly 2^k clock cycles, which is half the rate of the selected tap. The first edge after a start is falling.
- R4: The first data bit appears on sdo once the start is accepted. sdo changes only after a falling shift edge, and never on the first falling edge of a transfer. Bit k of the transfer (k = 0..7) is tx_byte[7-k] when lsb_first is 0 and tx_byte[k] when lsb_first is 1.
- R5: The block samples sdio_i on each rising shift edge. When lsb_first is 0, the first sampled bit ends up in rx_byte[7]. When lsb_first is 1, it ends up in rx_byte[0].
- R6: done rises and busy falls at the rising shift edge that completes the eighth bit. done stays set until a start is accepted, which clears it.
- R7: While busy, a start strobe has no effect: the byte on sdo is not reloaded and the transfer continues. A start strobe while enable is 0 is also ignored.
- R8: In external mode (enable 1, ext_clk 1), sck_oe is 0. Rising and falling edges of sck_i, after the two-flop synchronizer, drive the same shifting as in R4 to R6.
- R9: sdio_oe equals enable AND sdio_drive, and sdio_o always equals sdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Serial function on; when 0 the clock pin carries the divided clock |
| ext_clk | input | 1 | 1 = shift clock taken from sck_i, 0 = generated internally |
| lsb_first | input | 1 | Static bit order: 1 = least significant bit first |
| div_sel | input | 4 | Prescaler tap select k (clamped to 1..12) |
| sdio_drive | input | 1 | Shared data pin drives the serial output when 1 |
| start | input | 1 | Start strobe, one cycle |
| tx_byte | input | 8 | Parallel byte to send |
| rx_byte | output | 8 | Parallel byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer complete |
| sck_i | input | 1 | Clock pin input value |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sdo | output | 1 | Dedicated serial data output |
| sdio_i | input | 1 | Shared data pin input value, serial receive source |
| sdio_o | output | 1 | Shared data pin output value |
| sdio_oe | output | 1 | Shared data pin output enable |

## Verification
On every cycle, the assertions check the following: prescaler ticks never fall in adjacent cycles; the synchronized edge detector never reports both edges at once; the internal clock changes only on a tick; sdo holds between falling edges; done and busy are never set together; done rises only right after a rising edge; and a start during a transfer never drops busy early. Only the bench scenarios can show the bit order of sent and received bytes, the exact phase lengths for each tap setting, the clamping of div_sel, external-clock transfers through the synchronizer, and how a stray start in mid-transfer leaves the byte untouched.

// File: rtl/sio_pkg.sv
// Package: shared constants and types of the synchronous serial port.
// Assumes: the prescaler tap range starts at 1 and ends at TAP_MAX.
package sio_pkg;
    localparam int TAP_MAX = 12;
    localparam int SEL_W   = $clog2(TAP_MAX + 1);

    // Source of shift events for the shifter
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    // One pair of shift events, never both high
    typedef struct packed {
        logic rise;
        logic fall;
    } shift_evt_t;
endpackage

// File: rtl/sio_presc.sv
// Module: free-running power-of-two prescaler with a selectable tap.
// Produces a one-cycle tick every 2^k cycles and a square wave whose high
// phase is 2^(k-1) cycles. k is the select value clamped to 1..TAP_MAX.
// Assumes: the select input is quasi-static.
module sio_presc #(
    parameter int TAP_MAX = sio_pkg::TAP_MAX,
    parameter int SEL_W   = $clog2(TAP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tap_tick,
    output logic             tap_level
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(TAP_MAX);

    logic [TAP_MAX-1:0] cnt;
    logic [SEL_W-1:0]   idx;
    logic [TAP_MAX-1:0] mask;
    logic [TAP_MAX-1:0] shifted;

    // Purpose: free-running count shared by every tap
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Purpose: clamp the select value into the legal tap range
    always_comb begin
        if (sel == '0)          idx = SEL_W'(1);
        else if (sel > SEL_MAX) idx = SEL_MAX;
        else                    idx = sel;
    end

    // Purpose: derive tick and square wave from the selected tap
    always_comb begin
        mask      = {TAP_MAX{1'b1}} >> (SEL_MAX - idx);
        shifted   = cnt >> (idx - SEL_W'(1));
        tap_tick  = ((cnt & mask) == mask);
        tap_level = shifted[0];
    end

    // R2: ticks are always at least two cycles apart
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tick |=> !tap_tick)
        else $error("tick in adjacent cycles");
endmodule

// File: rtl/sio_edge.sv
// Module: two-flop synchronizer plus edge detector for the clock pin.
// Emits one-cycle rise and fall pulses three flops after the pin edge.
// Assumes: the pin idles high and its half period exceeds three cycles.
module sio_edge (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin,
    output sio_pkg::shift_evt_t evt
);
    logic meta_q, sync_q, last_q;

    // Purpose: synchronize the pin and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Purpose: compare synchronized sample with the previous one
    always_comb begin
        evt.rise = sync_q & ~last_q;
        evt.fall = ~sync_q & last_q;
    end

    // R8: the detector never reports both edges in one cycle
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.rise && evt.fall))
        else $error("both edges at once");
endmodule

// File: rtl/sio_sclk.sv
// Module: internal shift-clock generator. Toggles on each prescaler tick
// while a transfer runs in internal mode and otherwise rests high.
// Assumes: a transfer always starts with the clock high.
module sio_sclk (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick,
    output logic                sck,
    output sio_pkg::shift_evt_t evt
);
    // Purpose: hold high when idle, toggle on tick when running
    always_ff @(posedge clk) begin
        if (!rst_n)        sck <= 1'b1;
        else if (!run)     sck <= 1'b1;
        else if (tick)     sck <= ~sck;
    end

    // Purpose: report the edge the next toggle will make
    always_comb begin
        evt.rise = run & tick & ~sck;
        evt.fall = run & tick & sck;
    end

    // R3: the internal clock changes level only on a prescaler tick or when resting
    a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> ($past(tick) || !$past(run)))
        else $error("shift clock moved without tick");
endmodule

// File: rtl/sio_shift.sv
// Module: bidirectional shift engine. Loads a word, presents bits on
// falling events (skipping the first) and captures on rising events.
// Assumes: rise and fall events never coincide; lsb_first is static per transfer.
module sio_shift #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [W-1:0]        load_data,
    input  logic                lsb_first,
    input  sio_pkg::shift_evt_t evt,
    input  logic                sin,
    output logic                sout,
    output logic [W-1:0]        rx_data,
    output logic                busy,
    output logic                done
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  tx_q;
    logic [CW-1:0] nrise;

    // Purpose: load, shift out, shift in and track completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_data <= '0;
            nrise   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else if (load) begin
            tx_q  <= load_data;
            nrise <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (evt.rise) begin
                rx_data <= lsb_first ? {sin, rx_data[W-1:1]} : {rx_data[W-2:0], sin};
                nrise   <= nrise + 1'b1;
                if (nrise == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
            if (evt.fall && nrise != '0) begin
                tx_q <= lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
            end
        end
    end

    // Purpose: present the current outgoing bit
    always_comb sout = lsb_first ? tx_q[0] : tx_q[W-1];

    // R4: outgoing bit holds unless a falling event or a load happens
    a_r4_sout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt.fall && !load) |=> (sout == $past(sout)))
        else $error("sdo moved without falling edge");

    // R6: done and busy are never set together
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done))
        else $error("busy and done both set");

    // R6: done only rises right after a rising event
    a_r6_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(evt.rise))
        else $error("done rose without rising edge");
endmodule

// File: rtl/sio_port.sv
// Module: top of the synchronous serial port. Chooses the shift-event
// source, gates the start strobe and drives the clock and data pins.
// Assumes: ext_clk and lsb_first do not change during a transfer.
module sio_port #(
    parameter int DATA_W  = 8,
    parameter int TAP_MAX = sio_pkg::TAP_MAX,
    parameter int SEL_W   = $clog2(TAP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ext_clk,
    input  logic              lsb_first,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              sdio_drive,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic              done,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe
);
    import sio_pkg::*;

    clk_src_e   src;
    logic       tap_tick, tap_level;
    logic       int_run, int_sck;
    logic       load;
    logic       sout;
    shift_evt_t int_evt, ext_evt, sel_evt;

    sio_presc #(.TAP_MAX(TAP_MAX), .SEL_W(SEL_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .sel(div_sel),
        .tap_tick(tap_tick), .tap_level(tap_level)
    );

    sio_edge i_edge (
        .clk(clk), .rst_n(rst_n), .pin(sck_i), .evt(ext_evt)
    );

    sio_sclk i_sclk (
        .clk(clk), .rst_n(rst_n), .run(int_run), .tick(tap_tick),
        .sck(int_sck), .evt(int_evt)
    );

    sio_shift #(.W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_byte),
        .lsb_first(lsb_first), .evt(sel_evt), .sin(sdio_i),
        .sout(sout), .rx_data(rx_byte), .busy(busy), .done(done)
    );

    // Purpose: select the shift-event source and accept starts
    always_comb begin
        src     = ext_clk ? SRC_EXTERNAL : SRC_INTERNAL;
        int_run = busy & enable & (src == SRC_INTERNAL);
        sel_evt = (src == SRC_EXTERNAL) ? ext_evt : int_evt;
        load    = start & enable & ~busy;
    end

    // Purpose: drive the clock pin and both data pins
    always_comb begin
        if (!enable) begin
            sck_o  = tap_level;
            sck_oe = 1'b1;
        end else if (src == SRC_EXTERNAL) begin
            sck_o  = 1'b1;
            sck_oe = 1'b0;
        end else begin
            sck_o  = int_sck;
            sck_oe = 1'b1;
        end
        sdo     = sout;
        sdio_o  = sout;
        sdio_oe = enable & sdio_drive;
    end

    // R7: a start during a transfer never ends it early
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !sel_evt.rise) |=> busy)
        else $error("start disturbed running transfer");
endmodule

// File: tb/test_sio_port.sv
`timescale 1ns/1ps
module test_sio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, ext_clk = 1'b0, lsb_first = 1'b0;
    logic [3:0] div_sel = 4'd1;
    logic       sdio_drive = 1'b0, start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       busy, done, sck_i = 1'b1, sck_o, sck_oe, sdo;
    logic       sdio_i = 1'b0, sdio_o, sdio_oe;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sio_port i_sio_port (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ext_clk(ext_clk),
        .lsb_first(lsb_first), .div_sel(div_sel), .sdio_drive(sdio_drive),
        .start(start), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy),
        .done(done), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdo(sdo), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic bitk(input logic [7:0] d, input int k, input logic lsb);
        if (k > 7) return 1'b0;
        return lsb ? d[k] : d[7-k];
    endfunction

    // Watchdog: an expired run is a failed check and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Internal-mode transfer; poke = rise count after which a stray start is given
    task automatic run_int(input logic [7:0] data, input logic [7:0] pat,
                           input logic lsb, input logic [3:0] sel, input int poke);
        int k, lowrun, expk;
        logic prev;
        expk = (sel == 0) ? 1 : sel;
        enable = 1'b1; ext_clk = 1'b0; lsb_first = lsb; div_sel = sel;
        sdio_drive = lsb; tx_byte = data; sdio_i = bitk(pat, 0, lsb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R6 start accepted", {busy, done}, 2);
        check(sdo == bitk(data, 0, lsb), "R4 first bit", sdo, bitk(data, 0, lsb));
        check(sck_oe == 1'b1 && sck_o == 1'b1, "R3 idle high", {sck_oe, sck_o}, 3);
        k = 0; lowrun = 0; prev = sck_o;
        while (k < 8) begin
            @(negedge clk);
            start = 1'b0;
            if (sck_o == 1'b0) lowrun++;
            if (prev == 1'b0 && sck_o == 1'b1) begin
                check(lowrun == (1 << expk), "R3 low phase", lowrun, 1 << expk);
                check(sdo == bitk(data, k, lsb), "R4 bit order", sdo, bitk(data, k, lsb));
                check(sdio_o == sdo && sdio_oe == lsb, "R9 shared pin", {sdio_oe, sdio_o}, {lsb, sdo});
                lowrun = 0;
                k++;
                sdio_i = bitk(pat, k, lsb);
                if (k == poke) begin
                    tx_byte = ~data;
                    start = 1'b1;
                end
                if (k < 8) check(busy == 1'b1, "R7 still busy", busy, 1);
            end
            prev = sck_o;
        end
        check(busy == 1'b0 && done == 1'b1, "R6 done at eighth rise", {busy, done}, 1);
        check(rx_byte == pat, "R5 received byte", rx_byte, pat);
        @(negedge clk);
        check(done == 1'b1 && sck_o == 1'b1, "R6 done held", {done, sck_o}, 3);
    endtask

    // External-mode transfer driven by the bench on sck_i, half period 6 cycles
    task automatic run_ext(input logic [7:0] data, input logic [7:0] pat, input logic lsb);
        enable = 1'b1; ext_clk = 1'b1; lsb_first = lsb; sdio_drive = 1'b0;
        tx_byte = data; sck_i = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sck_oe == 1'b0 && sdio_oe == 1'b0, "R8 clock pin input", {sck_oe, sdio_oe}, 0);
        for (int k = 0; k < 8; k++) begin
            sck_i = 1'b0;
            sdio_i = bitk(pat, k, lsb);
            repeat (6) @(negedge clk);
            check(sdo == bitk(data, k, lsb), "R8 external bit", sdo, bitk(data, k, lsb));
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(busy == 1'b0 && done == 1'b1, "R8 external done", {busy, done}, 1);
        check(rx_byte == pat, "R8 external receive", rx_byte, pat);
    endtask

    // Divided clock run length with the serial function off
    task automatic check_div(input logic [3:0] sel, input int exp_run);
        int run;
        enable = 1'b0; div_sel = sel;
        @(negedge clk);
        while (sck_o != 1'b0) @(negedge clk);
        while (sck_o != 1'b1) @(negedge clk);
        run = 0;
        while (sck_o == 1'b1) begin
            run++;
            @(negedge clk);
        end
        check(run == exp_run && sck_oe == 1'b1, "R2 divided clock", run, exp_run);
    endtask

    initial begin
        logic [7:0] vals [3];
        vals[0] = 8'hA5; vals[1] = 8'h01; vals[2] = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && rx_byte == 8'h00, "R1 reset state",
              {busy, done, rx_byte}, 0);

        check_div(4'd3, 4);
        check_div(4'd0, 1);
        check_div(4'd15, 2048);

        // R7: start ignored while disabled
        enable = 1'b0; start = 1'b1; tx_byte = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R7 disabled start", {busy, done}, 0);

        for (int s = 1; s <= 3; s++)
            for (int l = 0; l < 2; l++)
                for (int v = 0; v < 3; v++)
                    run_int(vals[v], ~vals[(v + 1) % 3], l[0], s[3:0], 99);

        run_int(8'h96, 8'h69, 1'b0, 4'd0, 99);   // R3 clamp of zero select
        run_int(8'hC3, 8'h81, 1'b0, 4'd1, 3);    // R7 stray start in mid-transfer
        run_int(8'h4E, 8'h7E, 1'b1, 4'd2, 5);    // R7 stray start, lsb first

        run_ext(8'hB2, 8'h1D, 1'b0);
        run_ext(8'hB2, 8'hE8, 1'b1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule